// File: doc/BRIEF.md
# Quadrature Encoder Counter with Configuration Lock

This block counts the position of one incremental encoder channel from its two phase inputs, A and B. Both phases pass through a two-flop synchroniser. The decoder then works in x4 mode: every edge of either phase moves the count by one. The count goes up when phase A leads phase B and down when B leads A.

The count stays inside a window set by an initial-value register and a modulo register, and it wraps at either end. A 3-bit prescaler lowers the rate at which the decoder samples its inputs. Software reaches the block through a simple word-addressed register bus with 32-bit data. A lock flag shields the configuration from stray writes, and a module-enable bit and a decode-enable bit together start and stop counting.

Word addresses: 0 control (bits 2:0 prescaler), 1 count, 2 modulo, 3 initial value, 4 status (bit 0 lock flag, bit 1 sticky phase error), 5 mode (bit 0 module enable, bit 1 unlock), 6 decode control (bit 0 decode enable). Reads return the register one cycle after the read strobe. Unused bits and unused addresses read as zero.

Top module: `qdec_timer`

## Requirements
- R1: After reset, the count and the initial value read 0 and the modulo reads 0xFFFF. Control, status, mode and decode control all read 0.
- R2: While counting is running and phase A leads phase B, each edge of either phase adds one to the count. The up sequence of (A,B) is 00, 10, 11, 01.
- R3: While counting is running and phase B leads phase A, each edge of either phase subtracts one from the count.
- R4: Counting up from the modulo value gives the initial value. Counting down from the initial value gives the modulo value.
- R5: Any write to the count address loads the count with the initial value, whatever the data. This write is accepted while the lock flag is set.
- R6: If both phases change between two samples, the count does not change and status bit 1 is set. Bit 1 stays set until reset.
- R7: Control bits 2:0 (p) make the decoder sample once every 2^p clocks. An accepted control write restarts the divider, so with p = 7 the first sample comes 128 clocks after the write.
- R8: Writing 1 to status bit 0 sets the lock flag. While the flag is set, writes to control, modulo, initial value, decode control and the enable bit of mode are ignored.
- R9: The lock flag is cleared only by a mode write with bit 1 set while the flag is set. That write leaves the module-enable bit unchanged. A status write of 0 does not clear the flag.
- R10: While mode bit 0 is 0, writes to the initial-value and decode-control registers are ignored.
- R11: The count moves only while both mode bit 0 and decode control bit 0 are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| enc_a | input | 1 | Encoder phase A, asynchronous |
| enc_b | input | 1 | Encoder phase B, asynchronous |

## Verification
The assertions assume that the bus strobes and address are clean and synchronous to the clock, and that the phase inputs can change at any time because they are synchronised inside the block. The bench drives the bus at the falling edge. It changes the phases one at a time and holds each state for several samples, so every legal step is seen exactly once. The only exception is one deliberate double change, made to exercise the error flag. The prescaler test holds the new phase state for longer than the 128-clock sample period.

// File: rtl/qdec_pkg.sv
package qdec_pkg;
  localparam int A_CTRL = 0;
  localparam int A_CNT  = 1;
  localparam int A_MOD  = 2;
  localparam int A_INIT = 3;
  localparam int A_STAT = 4;
  localparam int A_MODE = 5;
  localparam int A_QCTL = 6;
endpackage

// File: rtl/qdec_sync.sv
module qdec_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= din;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/qdec_prescaler.sv
module qdec_prescaler #(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic [PS_W-1:0] ps,
  output logic            tick
);
  localparam int DIV_W = (1 << PS_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] limit;

  assign limit = {DIV_W{1'b1}} >> (DIV_W - int'(ps));
  assign tick  = (div_q == limit);

  always_ff @(posedge clk) begin
    if (rst || clr)  div_q <= '0;
    else if (tick)   div_q <= '0;
    else             div_q <= div_q + 1'b1;
  end

  // R7
  tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && ps != '0 && !clr) |=> !tick);
endmodule

// File: rtl/qdec_decode.sv
module qdec_decode (
  input  logic clk,
  input  logic rst,
  input  logic smp,
  input  logic a,
  input  logic b,
  output logic up,
  output logic dn,
  output logic bad
);
  logic a_q, b_q;
  logic da, db;

  assign da  = a ^ a_q;
  assign db  = b ^ b_q;
  assign up  = smp && (da ^ db) && (a ^ b_q);
  assign dn  = smp && (da ^ db) && !(a ^ b_q);
  assign bad = smp && da && db;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= 1'b0;
      b_q <= 1'b0;
    end else if (smp) begin
      a_q <= a;
      b_q <= b;
    end
  end

  // R2
  step_once_chk: assert property (@(posedge clk) disable iff (rst)
    (up || dn) |=> ((a_q ^ b_q) != $past(a_q ^ b_q)));
endmodule

// File: rtl/qdec_timer.sv
module qdec_timer #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter int CNT_W  = 16,
  parameter int PS_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              enc_a,
  input  logic              enc_b
);
  import qdec_pkg::*;

  logic [CNT_W-1:0] cnt_q, init_q, mod_q;
  logic [PS_W-1:0]  ps_q;
  logic             wp_q, err_q, men_q, qen_q;
  logic [1:0]       ph_s;
  logic             tick, up, dn, bad, run;
  logic             sel_ctrl, sel_cnt, sel_mod, sel_init, sel_stat, sel_mode, sel_qctl;
  logic             wr_ctrl;

  assign sel_ctrl = bus_addr == ADDR_W'(A_CTRL);
  assign sel_cnt  = bus_addr == ADDR_W'(A_CNT);
  assign sel_mod  = bus_addr == ADDR_W'(A_MOD);
  assign sel_init = bus_addr == ADDR_W'(A_INIT);
  assign sel_stat = bus_addr == ADDR_W'(A_STAT);
  assign sel_mode = bus_addr == ADDR_W'(A_MODE);
  assign sel_qctl = bus_addr == ADDR_W'(A_QCTL);
  assign wr_ctrl  = bus_wr && sel_ctrl && !wp_q;
  assign run      = men_q && qen_q;

  qdec_sync #(.WIDTH(2), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .din({enc_a, enc_b}), .dout(ph_s));

  qdec_prescaler #(.PS_W(PS_W)) u_pre (
    .clk(clk), .rst(rst), .clr(wr_ctrl), .ps(ps_q), .tick(tick));

  qdec_decode u_dec (
    .clk(clk), .rst(rst), .smp(tick), .a(ph_s[1]), .b(ph_s[0]),
    .up(up), .dn(dn), .bad(bad));

  always_ff @(posedge clk) begin
    if (rst) begin
      ps_q   <= '0;
      init_q <= '0;
      mod_q  <= '1;
      wp_q   <= 1'b0;
      men_q  <= 1'b0;
      qen_q  <= 1'b0;
    end else if (bus_wr) begin
      if (wr_ctrl) ps_q <= bus_wdata[PS_W-1:0];
      if (sel_mod && !wp_q) mod_q <= bus_wdata[CNT_W-1:0];
      if (sel_init && !wp_q && men_q) init_q <= bus_wdata[CNT_W-1:0];
      if (sel_qctl && !wp_q && men_q) qen_q <= bus_wdata[0];
      if (sel_stat && bus_wdata[0]) wp_q <= 1'b1;
      if (sel_mode) begin
        if (wp_q) begin
          if (bus_wdata[1]) wp_q <= 1'b0;
        end else begin
          men_q <= bus_wdata[0];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (run && bad) err_q <= 1'b1;
      if (bus_wr && sel_cnt)         cnt_q <= init_q;
      else if (run && up)            cnt_q <= (cnt_q == mod_q)  ? init_q : cnt_q + 1'b1;
      else if (run && dn)            cnt_q <= (cnt_q == init_q) ? mod_q  : cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= '0;
      case (int'(bus_addr))
        A_CTRL:  bus_rdata <= DATA_W'(ps_q);
        A_CNT:   bus_rdata <= DATA_W'(cnt_q);
        A_MOD:   bus_rdata <= DATA_W'(mod_q);
        A_INIT:  bus_rdata <= DATA_W'(init_q);
        A_STAT:  bus_rdata <= DATA_W'({err_q, wp_q});
        A_MODE:  bus_rdata <= DATA_W'(men_q);
        A_QCTL:  bus_rdata <= DATA_W'(qen_q);
        default: bus_rdata <= '0;
      endcase
    end
  end

  // R5
  cnt_reload_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && sel_cnt) |=> (cnt_q == $past(init_q)));
  // R4
  wrap_up_chk: assert property (@(posedge clk) disable iff (rst)
    (run && up && !(bus_wr && sel_cnt) && cnt_q == mod_q) |=> (cnt_q == $past(init_q)));
  // R8
  wp_block_chk: assert property (@(posedge clk) disable iff (rst)
    (wp_q && bus_wr && sel_mod) |=> $stable(mod_q));
  // R9
  wp_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(wp_q) |-> $past(bus_wr && sel_mode && bus_wdata[1]));
  // R10
  men_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (!men_q && bus_wr && sel_init) |=> $stable(init_q));
  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !(bus_wr && sel_cnt)) |=> $stable(cnt_q));
  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q);
endmodule

// File: tb/qdec_timer_bench.sv
module qdec_timer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        enc_a = 1'b0, enc_b = 1'b0;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  localparam int CTRL = 0, CNT = 1, MOD = 2, INIT = 3, STAT = 4, MODE = 5, QCTL = 6;

  always #2 clk = ~clk;

  qdec_timer u_qdec_timer (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .enc_a(enc_a), .enc_b(enc_b));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(int addr, logic [31:0] data);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 3'(addr); bus_wdata = data;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(string req, int addr, logic [31:0] exp);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 3'(addr);
    @(negedge clk);
    bus_rd = 1'b0;
    check(req, bus_rdata, exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic step_up(int hold = 6);
    logic na;
    na = ~enc_b; enc_b = enc_a; enc_a = na;
    idle(hold);
  endtask

  task automatic step_dn(int hold = 6);
    logic nb;
    nb = ~enc_a; enc_a = enc_b; enc_b = nb;
    idle(hold);
  endtask

  task automatic t_reset;
    rd_chk("R1 count", CNT, 0);
    rd_chk("R1 init", INIT, 0);
    rd_chk("R1 modulo", MOD, 32'hFFFF);
    rd_chk("R1 control", CTRL, 0);
    rd_chk("R1 status", STAT, 0);
    rd_chk("R1 mode", MODE, 0);
    rd_chk("R1 decode ctl", QCTL, 0);
  endtask

  task automatic t_updown;
    wr(MODE, 1); wr(QCTL, 1);
    for (int i = 0; i < 4; i++) step_up();
    rd_chk("R2 up four edges", CNT, 4);
    step_up();
    rd_chk("R2 fifth edge", CNT, 5);
    for (int i = 0; i < 5; i++) step_dn();
    rd_chk("R3 down to zero", CNT, 0);
    step_dn();
    rd_chk("R4 down wrap to modulo", CNT, 32'hFFFF);
    step_up();
    rd_chk("R4 up wrap to init", CNT, 0);
  endtask

  task automatic t_window;
    wr(INIT, 5); wr(MOD, 8);
    wr(CNT, 32'hABCD);
    rd_chk("R5 reload ignores data", CNT, 5);
    for (int i = 0; i < 4; i++) step_up();
    rd_chk("R4 wrap 8 to 5", CNT, 5);
    step_dn();
    rd_chk("R4 wrap 5 to 8", CNT, 8);
    wr(INIT, 0); wr(MOD, 32'hFFFF); wr(CNT, 0);
  endtask

  task automatic t_illegal;
    enc_a = ~enc_a; enc_b = ~enc_b;
    idle(6);
    rd_chk("R6 double change no count", CNT, 0);
    rd_chk("R6 error flag set", STAT, 2);
    step_up();
    rd_chk("R6 counting resumes", CNT, 1);
    rd_chk("R6 error flag sticky", STAT, 2);
  endtask

  task automatic t_prescale;
    wr(CTRL, 7);
    rd_chk("R7 control readback", CTRL, 7);
    step_up(20);
    rd_chk("R7 no sample before period", CNT, 1);
    idle(120);
    rd_chk("R7 sample after period", CNT, 2);
    wr(CTRL, 0);
    step_up();
    rd_chk("R7 divide by one", CNT, 3);
  endtask

  task automatic t_enable;
    wr(QCTL, 0);
    step_up();
    rd_chk("R11 decode off holds", CNT, 3);
    wr(QCTL, 1);
    rd_chk("R11 no jump on re-enable", CNT, 3);
    wr(MODE, 0);
    step_up();
    rd_chk("R11 module off holds", CNT, 3);
    wr(INIT, 9);
    rd_chk("R10 init ignored", INIT, 0);
    wr(QCTL, 0);
    rd_chk("R10 decode ctl ignored", QCTL, 1);
    wr(MODE, 1);
    step_up();
    rd_chk("R11 resumes", CNT, 4);
  endtask

  task automatic t_lock;
    wr(STAT, 1);
    rd_chk("R8 lock set", STAT, 3);
    wr(MOD, 32'h33); rd_chk("R8 modulo locked", MOD, 32'hFFFF);
    wr(INIT, 7);     rd_chk("R8 init locked", INIT, 0);
    wr(CTRL, 5);     rd_chk("R8 control locked", CTRL, 0);
    wr(QCTL, 0);     rd_chk("R8 decode ctl locked", QCTL, 1);
    wr(MODE, 0);     rd_chk("R8 enable locked", MODE, 1);
    wr(STAT, 0);     rd_chk("R9 status 0 keeps lock", STAT, 3);
    wr(MODE, 0);     rd_chk("R9 mode bit1 clear keeps lock", STAT, 3);
    step_up();
    rd_chk("R8 counting while locked", CNT, 5);
    wr(CNT, 32'h1234);
    rd_chk("R5 reload while locked", CNT, 0);
    wr(MODE, 2);
    rd_chk("R9 lock cleared", STAT, 2);
    rd_chk("R9 enable kept", MODE, 1);
    wr(MOD, 32'h33);
    rd_chk("R9 modulo writable again", MOD, 32'h33);
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    t_reset();
    t_updown();
    t_window();
    t_illegal();
    t_prescale();
    t_enable();
    t_lock();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule